// File: doc/BRIEF.md
# Sticky Fault Cause Register

This block keeps an 8-bit record of what pulled the system into reset. Four supervisor sources feed it: primary supply low, secondary supply low, watchdog expiry and manual reset. A source that is active at a clock edge sets its own bit in that edge. The bit then stays set after the source goes quiet, until software writes it back to zero. Software can therefore learn the cause of the last reset after the processor comes back up.

Software reaches the register through a simple single-byte port driven by a serial slave: a write strobe and a read strobe, an address, write data, and registered read data with a one-cycle valid pulse. Only the register's own address, 0xFF, is decoded. No write-enable unlock is needed before a write. A fault that arrives in the same cycle as a clearing write is kept, so no fault is lost to a write.

Top module: `fault_cause_reg`

## Requirements
- R1: A synchronous active-high reset clears every cause bit and holds `rd_valid` low, so the first read after reset returns 0x00.
- R2: Byte layout: bit 7 = primary supply fail, bit 6 = secondary supply fail, bit 4 = watchdog fail, bit 3 = manual reset fail. Bits 5, 2, 1 and 0 always read 0, and writing 1 to them has no effect.
- R3: A source input that is high at a rising clock edge sets its cause bit at that edge. A one-cycle pulse is enough.
- R4: A cause bit stays at 1 after its source returns low, across any number of idle cycles and reads, until a write clears it.
- R5: A write (`wr_en` high, `addr` = 0xFF) loads `wdata` into the four cause bits at that edge. Writing 0 clears a bit and writing 1 sets it. No prior unlock access is needed.
- R6: If a source is high in the same cycle as a write that would clear its bit, the bit ends the cycle at 1.
- R7: A read (`rd_en` high, `addr` = 0xFF) raises `rd_valid` for one cycle after that edge. `rdata` then holds the register value from before any update made at that same edge.
- R8: A write or read at any address other than 0xFF changes no cause bit and produces no `rd_valid` pulse.
- R9: Several sources active in the same cycle all set their bits together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prim_fail | input | 1 | Primary supply below threshold |
| sec_fail | input | 1 | Secondary supply below threshold |
| wdog_fail | input | 1 | Watchdog output active |
| mrst_fail | input | 1 | Manual reset input active |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address from the serial slave |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rdata` valid |

## Verification
The assertions assume that the source inputs and the access strobes are synchronous to `clk` and stable around the rising edge. They also assume level capture, the default, in which a source that is high at an edge means an event. The bench changes every input only at the falling edge. It holds sources high for one or more whole cycles, both as one-cycle pulses and as long levels that overlap clearing writes. It keeps a one-cycle idle gap before each reset so that no read is left in flight when reset arrives.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned IDX_W    = $clog2(DATA_W);

  // source indices inside the capture vector
  localparam int unsigned SRC_PRIM = 0;
  localparam int unsigned SRC_SEC  = 1;
  localparam int unsigned SRC_WDOG = 2;
  localparam int unsigned SRC_MRST = 3;

  // bit position of each source inside the visible byte
  function automatic logic [IDX_W-1:0] src_pos(input int unsigned s);
    case (s)
      SRC_PRIM: src_pos = IDX_W'(7);
      SRC_SEC:  src_pos = IDX_W'(6);
      SRC_WDOG: src_pos = IDX_W'(4);
      default:  src_pos = IDX_W'(3);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] live_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) m[src_pos(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic match;
  assign match  = (addr == REG_ADDR);
  assign wr_hit = wr_en && match;
  assign rd_hit = rd_en && match;
endmodule

// File: rtl/fcr_sticky_bit.sv
module fcr_sticky_bit #(
  parameter bit EDGE_SET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic q
);
  logic event_now;

  generate
    if (EDGE_SET) begin : g_edge
      logic src_d;
      always_ff @(posedge clk) begin
        if (rst) src_d <= 1'b0;
        else     src_d <= src;
      end
      assign event_now = src && !src_d;
    end else begin : g_level
      assign event_now = src;
    end
  endgenerate

  // event has priority over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (event_now) q <= 1'b1;
    else if (wr_hit)    q <= wr_bit;
  end
endmodule

// File: rtl/fcr_read_port.sv
module fcr_read_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] cur_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rdata <= cur_byte;
    end
  end
endmodule

// File: rtl/fault_cause_reg.sv
module fault_cause_reg #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1,
  parameter bit                EDGE_SET = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      prim_fail,
  input  logic                      sec_fail,
  input  logic                      wdog_fail,
  input  logic                      mrst_fail,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [fcr_pkg::DATA_W-1:0] wdata,
  output logic [fcr_pkg::DATA_W-1:0] rdata,
  output logic                      rd_valid
);
  import fcr_pkg::*;

  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] cause_q;
  logic [DATA_W-1:0]  cause_byte;
  logic               wr_hit;
  logic               rd_hit;

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_PRIM] = prim_fail;
    src_vec[SRC_SEC]  = sec_fail;
    src_vec[SRC_WDOG] = wdog_fail;
    src_vec[SRC_MRST] = mrst_fail;
  end

  fcr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      fcr_sticky_bit #(.EDGE_SET(EDGE_SET)) u_bit (
        .clk   (clk),
        .rst   (rst),
        .src   (src_vec[s]),
        .wr_hit(wr_hit),
        .wr_bit(wdata[src_pos(s)]),
        .q     (cause_q[s])
      );
    end
  endgenerate

  // reserved positions stay zero
  always_comb begin
    cause_byte = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) cause_byte[src_pos(s)] = cause_q[s];
  end

  fcr_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .cur_byte(cause_byte),
    .rdata   (rdata),
    .rd_valid(rd_valid)
  );
endmodule

// File: rtl/fault_cause_reg_chk.sv
module fault_cause_reg_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1,
  parameter bit                EDGE_SET = 1'b0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [fcr_pkg::NUM_SRC-1:0] src_vec,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [fcr_pkg::DATA_W-1:0] wdata,
  input logic [fcr_pkg::DATA_W-1:0] rdata,
  input logic                       rd_valid,
  input logic [fcr_pkg::NUM_SRC-1:0] cause_q
);
  import fcr_pkg::*;
  localparam logic [DATA_W-1:0] MASK = live_mask();

  logic wr_acc, rd_acc;
  assign wr_acc = wr_en && (addr == REG_ADDR);
  assign rd_acc = rd_en && (addr == REG_ADDR);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cause_q == '0) && !rd_valid);  // R1

  AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rdata & ~MASK) == '0));  // R2

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rd_valid);  // R7

  AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> !rd_valid);  // R8

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      localparam logic [IDX_W-1:0] P = src_pos(s);

      AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rdata[P] == $past(cause_q[s]));  // R7

      AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        cause_q[s] && !(wr_acc && !wdata[P]) |=> cause_q[s]);  // R4

      AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_acc && !wdata[P] && !src_vec[s] |=> !cause_q[s]);  // R5

      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        !cause_q[s] && !src_vec[s] && !(wr_acc && wdata[P]) |=> !cause_q[s]);  // R8

      if (!EDGE_SET) begin : g_lvl
        AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
          src_vec[s] |=> cause_q[s]);  // R3

        AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
          wr_acc && src_vec[s] |=> cause_q[s]);  // R6
      end
    end
  endgenerate
endmodule

bind fault_cause_reg fault_cause_reg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .EDGE_SET(EDGE_SET)
) u_chk (
  .clk(clk), .rst(rst), .src_vec(src_vec), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .cause_q(cause_q)
);

// File: tb/fault_cause_reg_test.sv
module fault_cause_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prim_fail = 0, sec_fail = 0, wdog_fail = 0, mrst_fail = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] model = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         exp_v = 0;
  bit         strict = 0;
  string      strict_tag = "";

  always #4 clk = ~clk;  // 125 MHz

  fault_cause_reg uut (
    .clk(clk), .rst(rst), .prim_fail(prim_fail), .sec_fail(sec_fail),
    .wdog_fail(wdog_fail), .mrst_fail(mrst_fail), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // R2 layout: ev[0]->bit7, ev[1]->bit6, ev[2]->bit4, ev[3]->bit3
  function automatic logic [7:0] ev_byte(input logic [3:0] ev);
    return {ev[0], ev[1], 1'b0, ev[2], ev[3], 3'b000};
  endfunction

  task automatic drive(input logic [3:0] ev, input bit wr, input bit rd,
                       input logic [7:0] a, input logic [7:0] wd,
                       input string tag, input bit chk_idle = 0);
    @(negedge clk);
    {mrst_fail, wdog_fail, sec_fail, prim_fail} = ev;
    wr_en = wr; rd_en = rd; addr = a; wdata = wd;
    exp_v = rd && (a == 8'hFF);
    strict = chk_idle;
    strict_tag = tag;
    if (exp_v) begin
      exp_q.push_back(model);
      tag_q.push_back(tag);
    end
    if (wr && a == 8'hFF) model = wd & 8'hD8;
    model = model | ev_byte(ev);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(4'b0, 0, 0, 8'h00, 8'h00, "idle");
  endtask

  task automatic rd_reg(input string tag);
    drive(4'b0, 0, 1, 8'hFF, 8'h00, tag);
  endtask

  task automatic wr_reg(input logic [7:0] v, input logic [3:0] ev, input string tag);
    drive(ev, 1, 0, 8'hFF, v, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {mrst_fail, wdog_fail, sec_fail, prim_fail} = 4'b0;
    wr_en = 0; rd_en = 0; exp_v = 0; strict = 0;
    model = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: scoreboard pop after each rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      if (rst) begin
        // R1: no read response during reset
        if (rd_valid !== 1'b0) begin
          checks++; errors++;
          $display("FAIL R1: rd_valid during reset act=%b exp=0", rd_valid);
        end
      end else if (exp_v) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_valid !== 1'b1 || rdata !== e) begin
          errors++;
          $display("FAIL %s: read act=%h/v%b exp=%h/v1", t, rdata, rd_valid, e);
        end
      end else begin
        if (strict) checks++;
        if (rd_valid !== 1'b0) begin
          if (!strict) checks++;
          errors++;
          $display("FAIL %s: unexpected rd_valid act=1 exp=0", strict_tag);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(1);
    rd_reg("R1 reset value");                    // 00
    idle(1);

    drive(4'b0001, 0, 0, 8'h00, 8'h00, "R3 prim pulse");
    idle(1);
    rd_reg("R3 primary bit7");                   // 80
    idle(5);
    rd_reg("R4 sticky after idle");              // 80
    rd_reg("R4 sticky after read");              // 80

    wr_reg(8'h00, 4'b0, "R5 clear");
    rd_reg("R5 cleared, no unlock");             // 00

    drive(4'b0010, 0, 0, 8'h00, 8'h00, "R3 sec pulse");
    rd_reg("R2 secondary bit6");                 // 40
    drive(4'b0100, 0, 0, 8'h00, 8'h00, "R3 wdog pulse");
    rd_reg("R2 watchdog bit4");                  // 50
    drive(4'b1000, 0, 0, 8'h00, 8'h00, "R3 mrst pulse");
    rd_reg("R2 manual bit3");                    // 58

    wr_reg(8'hFF, 4'b0, "R2 write ones");
    rd_reg("R2 reserved bits ignore writes");    // D8
    wr_reg(8'h40, 4'b0, "R5 partial write");
    rd_reg("R5 loads written value");            // 40

    wr_reg(8'h00, 4'b0100, "R6 clear vs wdog");
    rd_reg("R6 event beats write");              // 10
    for (int i = 0; i < 3; i++) wr_reg(8'h00, 4'b0100, "R6 held level");
    rd_reg("R6 held level survives clears");     // 10
    wr_reg(8'h00, 4'b0, "R5 clear after level drops");
    rd_reg("R5 clear after level drops");        // 00

    drive(4'b0000, 1, 0, 8'h7F, 8'hFF, "R8 write other addr", 1);
    rd_reg("R8 other-address write no effect");  // 00
    drive(4'b0000, 0, 1, 8'h7F, 8'h00, "R8 read other addr", 1);
    drive(4'b0000, 0, 0, 8'h00, 8'h00, "R8 no valid after foreign read", 1);

    drive(4'b0001, 0, 1, 8'hFF, 8'h00, "R7 read with event");   // 00 (old)
    rd_reg("R7 next read sees event");           // 80
    drive(4'b0000, 1, 1, 8'hFF, 8'h00, "R7 read with write");   // 80 (old)
    rd_reg("R7 after write");                    // 00

    drive(4'b1111, 0, 0, 8'h00, 8'h00, "R9 all events");
    rd_reg("R9 all causes together");            // D8
    rd_reg("R9 back-to-back read");              // D8

    idle(1);
    do_reset();
    rd_reg("R1 reset clears set bits");          // 00
    idle(2);

    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7: reads unanswered act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule